// File: doc/BRIEF.md
# Overlapping Serial 0110 Detector

This block watches a serial bit stream and raises a single match flag in the same clock cycle as the bit that completes the pattern 0110. Bits are taken only on cycles where a valid strobe is high, so a producer can pause the stream without losing progress. Occurrences may overlap: the closing 0 of one match also serves as the opening 0 of the next.

The block is a four-state Mealy machine with a 2-bit binary state encoding. The match output is combinational. It is formed from the registered state and the current input bit, and it is gated by the valid strobe and by reset. A synchronous active-high reset returns the machine to the state with no progress.

Top module: `serial_match_fsm`

## Requirements
- R1: While `rst` is high, `hit` is 0, whatever the values on `in_vld` and `in_bit`. After the next clock edge the machine holds no progress.
- R2: `hit` is 1 in a cycle exactly when `in_vld` is 1, `rst` is 0, and the last four accepted bits, oldest first and counting the current bit as newest, are 0,1,1,0. There is no added cycle of latency.
- R3: Occurrences that overlap are detected. The accepted stream 111011011011 produces the `hit` sequence 000000100100.
- R4: On a cycle with `in_vld` low, `hit` is 0, `in_bit` is ignored, and the progress made so far is kept for the next accepted bit.
- R5: A 0 that arrives while the progress is "seen 0" or "seen 01" leaves the progress at "seen 0". So 000110 and 010110 each give a match on their last bit.
- R6: A 1 that arrives after 011 clears all progress. In 0111 followed by 110, no match occurs.
- R7: A reset pulse discards partial progress. After 011, one reset cycle and then a 0, `hit` stays 0.
- R8: The state uses a 2-bit binary code: 0 = no progress, 1 = seen 0, 2 = seen 01, 3 = seen 011. Any code not handled returns to no progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state advances on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | High when `in_bit` carries a bit to accept |
| in_bit | input | 1 | Serial data bit |
| hit | output | 1 | Combinational match flag for the current bit |

## Verification
The bound checker keeps its own record of the last accepted bits. On every cycle it checks that `hit` equals the pattern test on that record. It also checks that `hit` is quiet during reset and on cycles where valid is low, that a match always closes on a 0, and that two accepted bits in a row never both match. The bench scenarios are needed to show the end-to-end behaviour: the fixed overlap stream, that progress survives gaps in valid, that reset throws away partial progress, and that the recovery paths after 0 and after 0111 behave as specified.

// File: rtl/smf_pkg.sv
package smf_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_NONE = 2'd0,
        ST_Z    = 2'd1,
        ST_ZO   = 2'd2,
        ST_ZOO  = 2'd3
    } smf_state_e;

    typedef struct packed {
        smf_state_e state;
    } smf_regs_t;

    localparam smf_regs_t SMF_RESET = '{state: ST_NONE};
endpackage

// File: rtl/smf_next.sv
module smf_next
    import smf_pkg::*;
(
    input  smf_regs_t cur_q,
    input  logic      rst,
    input  logic      in_vld,
    input  logic      in_bit,
    output smf_regs_t nxt_d,
    output logic      hit
);
    always_comb begin
        nxt_d = cur_q;
        hit   = 1'b0;
        if (rst) begin
            nxt_d = SMF_RESET;
        end else if (in_vld) begin
            case (cur_q.state)
                ST_NONE: nxt_d.state = in_bit ? ST_NONE : ST_Z;
                ST_Z:    nxt_d.state = in_bit ? ST_ZO   : ST_Z;
                ST_ZO:   nxt_d.state = in_bit ? ST_ZOO  : ST_Z;
                ST_ZOO: begin
                    nxt_d.state = in_bit ? ST_NONE : ST_Z;
                    hit         = ~in_bit;
                end
                default: nxt_d.state = ST_NONE;
            endcase
        end
    end
endmodule

// File: rtl/smf_regs.sv
module smf_regs
    import smf_pkg::*;
(
    input  logic      clk,
    input  smf_regs_t nxt_d,
    output smf_regs_t cur_q
);
    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end
endmodule

// File: rtl/serial_match_fsm.sv
module serial_match_fsm
    import smf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_vld,
    input  logic in_bit,
    output logic hit
);
    smf_regs_t cur_q;
    smf_regs_t nxt_d;

    smf_next u_next (
        .cur_q  (cur_q),
        .rst    (rst),
        .in_vld (in_vld),
        .in_bit (in_bit),
        .nxt_d  (nxt_d),
        .hit    (hit)
    );

    smf_regs u_regs (
        .clk   (clk),
        .nxt_d (nxt_d),
        .cur_q (cur_q)
    );
endmodule

// File: rtl/smf_checker.sv
module smf_checker (
    input logic clk,
    input logic rst,
    input logic in_vld,
    input logic in_bit,
    input logic hit
);
    logic [2:0] seen_q;
    logic [1:0] depth_q;
    logic       want;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= 3'b000;
            depth_q <= 2'd0;
        end else if (in_vld) begin
            seen_q <= {seen_q[1:0], in_bit};
            if (depth_q != 2'd3) depth_q <= depth_q + 2'd1;
        end
    end

    assign want = in_vld && (depth_q == 2'd3) && (seen_q == 3'b011) && !in_bit;

    AST_RESET_QUIET: assert property (@(posedge clk) rst |-> !hit); // R1
    AST_MATCHES_MODEL: assert property (@(posedge clk) disable iff (rst) hit == want); // R2
    AST_GAP_QUIET: assert property (@(posedge clk) disable iff (rst) !in_vld |-> !hit); // R4
    AST_CLOSES_ON_ZERO: assert property (@(posedge clk) disable iff (rst) hit |-> !in_bit); // R2
    AST_NO_ADJACENT_HIT: assert property (@(posedge clk) disable iff (rst) (hit && in_vld) |=> !hit); // R3
endmodule

bind serial_match_fsm smf_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .in_vld (in_vld),
    .in_bit (in_bit),
    .hit    (hit)
);

// File: tb/serial_match_fsm_bench.sv
`timescale 1ns/1ps
module serial_match_fsm_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_vld = 1'b0;
    logic in_bit = 1'b0;
    logic hit;

    int total = 0;
    int bad = 0;
    logic exp_q[$];
    string tag_q[$];
    logic [2:0] m_hist = 3'b000;
    int m_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    serial_match_fsm u_serial_match_fsm (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_bit(in_bit), .hit(hit)
    );

    function automatic logic model_exp(input logic r, input logic v, input logic b);
        return !r && v && (m_cnt >= 3) && (m_hist == 3'b011) && !b;
    endfunction

    task automatic drive(input logic r, input logic v, input logic b, input logic e, input string tag);
        @(negedge clk);
        rst = r; in_vld = v; in_bit = b;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (r) begin m_hist = 3'b000; m_cnt = 0; end
        else if (v) begin m_hist = {m_hist[1:0], b}; m_cnt++; end
    endtask

    task automatic bits(input string s, input string e, input string tag);
        for (int i = 0; i < s.len(); i++)
            drive(1'b0, 1'b1, s[i] == "1", e[i] == "1", tag);
    endtask

    always begin
        @(negedge clk);
        #1;
        if (exp_q.size() != 0) begin
            logic e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (hit !== e) begin
                bad++;
                $display("FAIL %s: hit=%b expected=%b", t, hit, e);
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        // R1: reset with data that would match if gating were absent
        drive(1'b1, 1'b1, 1'b0, 1'b0, "R1");
        drive(1'b1, 1'b0, 1'b1, 1'b0, "R1");
        bits("011", "000", "R2");
        drive(1'b1, 1'b1, 1'b0, 1'b0, "R1");
        // R7: progress 011 discarded by reset, then 0 gives no match
        drive(1'b0, 1'b1, 1'b0, 1'b0, "R7");
        drive(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        // R3: reference overlap stream
        bits("111011011011", "000000100100", "R3");
        drive(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        // R2: plain match then shared-zero and fresh-zero repeats
        bits("0110110", "0001001", "R2");
        bits("0110", "0001", "R2");
        drive(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        // R4: gaps with junk data keep progress and stay quiet
        drive(1'b0, 1'b1, 1'b0, 1'b0, "R4");
        drive(1'b0, 1'b0, 1'b1, 1'b0, "R4");
        drive(1'b0, 1'b1, 1'b1, 1'b0, "R4");
        drive(1'b0, 1'b0, 1'b0, 1'b0, "R4");
        drive(1'b0, 1'b0, 1'b0, 1'b0, "R4");
        drive(1'b0, 1'b1, 1'b1, 1'b0, "R4");
        drive(1'b0, 1'b0, 1'b0, 1'b0, "R4");
        drive(1'b0, 1'b1, 1'b0, 1'b1, "R4");
        drive(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        // R5: repeated zeros and a broken 01 both keep seen-0 progress
        bits("000110", "000001", "R5");
        drive(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        bits("010110", "000001", "R5");
        drive(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        // R6: 0111 clears progress
        bits("0111110", "0000000", "R6");
        bits("110", "001", "R6");
        drive(1'b1, 1'b0, 1'b0, 1'b0, "R1");
        // R8: run every code through its transitions against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            logic v, b, r;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            v = lfsr[3] | lfsr[7];
            b = lfsr[0] ^ lfsr[9];
            r = (lfsr[15:11] == 5'd0);
            drive(r, v, b, model_exp(r, v, b), "R2/R8 random");
        end
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule